// File: doc/BRIEF.md
# Quinary-Binary Digit Output Checker

This block is the last stage of a decimal digit adder that works in a seven-line quinary-binary code. Each digit arrives as five quinary lines, weighted 0, 2, 4, 6 and 8, and two binary lines, weighted 0 and 1. A good code has exactly one quinary line and exactly one binary line set, and its value is the sum of the two weights. The stage turns a good code into a four-bit decimal digit and a check bit. Any code that breaks the one-of-five and one-of-two rule raises a fault flag.

The check bit and the fault logic are built from the same terms. The quinary lines form two parity groups. Weights 0 and 6 give an even bit count in the output digit when paired with binary 0. Weights 2, 4 and 8 give an odd bit count in that case. The check bit is formed from the group signals and the binary line. The fault logic tests the two group signals against each other: a fault is flagged when both groups are active or when neither is. Pairs of lines inside one group are caught separately.

The digit, check bit and fault flag are purely combinational. A registered halt output takes in the fault flag whenever a strobe is high. Once set, it stays set until a synchronous reset clears it.

Top module: `qb_digit_out`

## Requirements
- R1: Input bit positions are fixed: `qb[6]`, `qb[5]`, `qb[4]`, `qb[3]`, `qb[2]` are the quinary lines of weight 8, 6, 4, 2, 0, and `qb[1]`, `qb[0]` are the binary lines of weight 1 and 0. For a valid code whose value is 1 to 9, `digit` is that value in plain 4-bit binary.
- R2: The valid code of value zero (quinary 0 with binary 0) gives `digit` = 4'b1010 and never 4'b0000.
- R3: For every valid code, `chk` makes the five bits {`digit`, `chk`} hold an odd number of ones. So `chk` is 1 exactly when `digit` has an even number of ones.
- R4: `fault` is 1 whenever both binary lines are 0 or both are 1.
- R5: `fault` is 1 whenever no quinary line is set. It is also 1 whenever a line of weight 0 or 6 and a line of weight 2, 4 or 8 are set together.
- R6: `fault` is 1 whenever two or more lines are set within {0, 6} or within {2, 4, 8}. As a result, `fault` is 0 for exactly the 10 valid codes out of all 128.
- R7: While `fault` is 1, `digit` is 4'b0000 and `chk` is 0.
- R8: A rising clock edge with `strobe` = 1 and `fault` = 1 sets `halt` to 1 from that edge on.
- R9: Once set, `halt` stays 1 at every following edge until an edge with `rst` = 1. A strobe with `fault` = 0 does not set it, and neither does a fault without a strobe.
- R10: An edge with `rst` = 1 makes `halt` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the halt register |
| rst | input | 1 | Synchronous active-high reset of halt |
| strobe | input | 1 | Samples the fault flag into halt |
| qb | input | 7 | Quinary-binary digit, layout per R1 |
| digit | output | 4 | Decimal digit, zero written as 1010 |
| chk | output | 1 | Odd-parity check bit over digit |
| fault | output | 1 | Invalid-code flag |
| halt | output | 1 | Sticky registered fault |

## Verification
The in-module properties check the relations among the outputs on every clock. A flagged digit is blanked with a clear check bit. An unflagged digit is a nonzero decimal value with odd overall parity. The halt register obeys its set, hold and stay-clear rules. Whether the fault flag picks out exactly the invalid codes, and whether each valid code maps to the right digit, is shown only by the bench. The bench sweeps all 128 input codes against a count-based model, and then runs a short halt sequence.

// File: rtl/qb_digit_out.sv
module qb_digit_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic [6:0] qb,
  output logic [3:0] digit,
  output logic       chk,
  output logic       fault,
  output logic       halt
);

  logic q8, q6, q4, q2, q0, b1, b0;
  assign {q8, q6, q4, q2, q0, b1, b0} = qb;

  logic grp_even, grp_odd;
  assign grp_even = q0 | q6;
  assign grp_odd  = q2 | q4 | q8;

  logic bin_bad, grp_bad, pair_bad;
  assign bin_bad  = ~(b0 ^ b1);
  assign grp_bad  = ~(grp_even ^ grp_odd);
  assign pair_bad = (q0 & q6) | (q2 & q4) | (q2 & q8) | (q4 & q8);
  assign fault    = bin_bad | grp_bad | pair_bad;

  logic [3:0] raw;
  assign raw[0] = b1;
  assign raw[1] = q2 | q6 | (q0 & b0);
  assign raw[2] = q4 | q6;
  assign raw[3] = q8 | (q0 & b0);

  assign digit = fault ? 4'b0000 : raw;
  assign chk   = ~fault & ((grp_even & b0) | (grp_odd & b1));

  always_ff @(posedge clk) begin
    if (rst)                  halt <= 1'b0;
    else if (strobe && fault) halt <= 1'b1;
  end

  // R7
  p_fault_blank_r7: assert property (@(posedge clk) disable iff (rst)
    fault |-> (digit == 4'b0000 && !chk));
  // R2 R3
  p_digit_legal_r2: assert property (@(posedge clk) disable iff (rst)
    !fault |-> (digit != 4'b0000 && (digit <= 4'd9 || digit == 4'b1010)));
  p_odd_parity_r3: assert property (@(posedge clk) disable iff (rst)
    !fault |-> ($countones({digit, chk}) % 2 == 1));
  // R8
  p_halt_set_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe && fault) |=> halt);
  // R9
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!halt && !(strobe && fault)) |=> !halt);

endmodule

// File: tb/qb_digit_out_tb.sv
`timescale 1ns/1ps
module qb_digit_out_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0;
  logic [6:0] qb = 7'b0000101;
  logic [3:0] digit;
  logic       chk, fault, halt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qb_digit_out u_dut (
    .clk(clk), .rst(rst), .strobe(strobe), .qb(qb),
    .digit(digit), .chk(chk), .fault(fault), .halt(halt)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (qb=%b)", tag, act, exp, qb);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick();
    check("R10 reset halt", halt, 0);
    rst = 1'b0;

    for (int c = 0; c < 128; c++) begin
      int qn, bn, qv, val, ev, od, ones;
      logic [3:0] ed;
      qb = c[6:0];
      #1;
      qn = c[6] + c[5] + c[4] + c[3] + c[2];
      bn = c[1] + c[0];
      qv = c[6] ? 8 : c[5] ? 6 : c[4] ? 4 : c[3] ? 2 : 0;
      val = qv + c[1];
      ev = c[5] + c[2];
      od = c[6] + c[4] + c[3];
      if (qn == 1 && bn == 1) begin
        ed = (val == 0) ? 4'b1010 : val[3:0];
        ones = ed[0] + ed[1] + ed[2] + ed[3];
        check("R6 valid no fault", fault, 0);
        if (val == 0) check("R2 zero code", digit, 10);
        else          check("R1 digit value", digit, ed);
        check("R3 odd parity", chk, (ones % 2 == 0) ? 1 : 0);
      end else begin
        if (bn != 1)
          check("R4 binary fault", fault, 1);
        else if (qn == 0 || (ev > 0 && od > 0))
          check("R5 group fault", fault, 1);
        else
          check("R6 same-group fault", fault, 1);
        check("R7 blank digit", digit, 0);
        check("R7 clear chk", chk, 0);
      end
    end

    qb = 7'b0010010;
    strobe = 1'b1;
    tick();
    check("R9 strobe on valid", halt, 0);
    qb = 7'b0011010;
    strobe = 1'b0;
    tick();
    check("R9 fault without strobe", halt, 0);
    strobe = 1'b1;
    tick();
    check("R8 halt set", halt, 1);
    qb = 7'b1000010;
    tick();
    check("R9 halt sticky", halt, 1);
    strobe = 1'b0;
    tick();
    tick();
    check("R9 halt held", halt, 1);
    rst = 1'b1;
    tick();
    check("R10 halt cleared", halt, 0);
    rst = 1'b0;
    tick();
    check("R9 stays clear", halt, 0);

    finish_run();
  end

endmodule